// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

The block holds an eight-bit word in which a single data bit is placed into one position chosen by a three-bit select. Two active-low controls decide what happens. One is a write strobe. The other is a clear whose effect depends on the strobe. Together they choose one of four modes:

- **Write:** the selected position is transparent to the data bit.
- **Hold:** everything is frozen.
- **Clear:** every bit is zeroed.
- **Demultiplex:** only the selected position shows the data bit and all other positions read zero.

This is a synchronous model. A system clock samples the controls, and the stored word changes only on clock edges. The visible output is formed combinationally from the stored word and the current mode, so the transparent paths respond within the cycle. A word is committed when the strobe returns high. The commit uses the data and select values sampled at the last clock edge at which the strobe was still low. A flag reports a select that moves while the strobe stays low, because that usage could write the wrong bit.

Top module: `bsl_addr_latch`

## Requirements
- R1: While `wr_n` is 0 and `clr_n` is 1, output bit `q[sel]` equals `din` in the same cycle, and every other output bit shows its stored value.
- R2: At a clock edge where `wr_n` is 1 and the previous edge sampled `wr_n` 0 (with `clr_n` 1), stored bit number `sel` takes `din`, both taken as sampled at that previous edge. No other stored bit changes. `q` shows the committed value as soon as `wr_n` is 1.
- R3: While `wr_n` is 1 and `clr_n` is 1 with no commit pending, `q` keeps its value whatever `din` and `sel` do.
- R4: While `wr_n` is 1 and `clr_n` is 0, `q` is all zeros at once, and the stored word is zero after the next clock edge.
- R5: While `wr_n` is 0 and `clr_n` is 0, `q` has `din` in position `sel` and zeros elsewhere. The stored word is zero after the next clock edge.
- R6: A clear (`clr_n` 0) at the edge where a commit would happen wins: the stored word becomes zero.
- R7: `sel_chg_err` is 1 exactly while `wr_n` is 0, `wr_n` was 0 at the previous clock edge, and `sel` differs from the value sampled at that edge.
- R8: While `rst_n` is 0 the stored word is zero and the previous strobe is taken as 1. Reset is applied asynchronously and released after two clock edges.
- R9: Select value k, with `sel[2]` most significant, addresses output bit `q[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Data bit |
| sel | input | 3 | Bit select, bit 2 most significant |
| wr_n | input | 1 | Active-low write strobe |
| clr_n | input | 1 | Active-low conditional clear |
| q | output | 8 | Latched word as seen in the current mode |
| sel_chg_err | output | 1 | Select changed while the strobe stayed low |

## Verification
The hardest situation to reach is a commit that collides with a clear. It needs the strobe released in the same cycle that the clear falls, after a cycle of transparent writing. The stimulus builds this case deliberately and then reads the word back in hold mode. A second difficult case is the exit from demultiplex mode: the clear is released while the strobe is still low, and that must leave a single committed bit. Every select value is walked in write and demultiplex modes with both data levels, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } bsl_mode_e;

  function automatic bsl_mode_e decode_mode(input logic wr_n, input logic clr_n);
    case ({wr_n, clr_n})
      2'b01:   return MODE_WRITE;
      2'b11:   return MODE_HOLD;
      2'b00:   return MODE_DEMUX;
      default: return MODE_CLEAR;
    endcase
  endfunction
endpackage

// File: rtl/bsl_rst_sync.sv
module bsl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bsl_sampler.sv
module bsl_sampler #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_n,
  output logic              din_q,
  output logic [ADDR_W-1:0] sel_q,
  output logic              wr_n_q,
  output logic              commit,
  output logic              sel_chg
);
  logic              din_nx;
  logic [ADDR_W-1:0] sel_nx;
  logic              wr_n_nx;

  always_comb begin
    din_nx  = din;
    sel_nx  = sel;
    wr_n_nx = wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q  <= 1'b0;
      sel_q  <= '0;
      wr_n_q <= 1'b1;
    end else begin
      din_q  <= din_nx;
      sel_q  <= sel_nx;
      wr_n_q <= wr_n_nx;
    end
  end

  assign commit  = wr_n & ~wr_n_q;
  assign sel_chg = ~wr_n & ~wr_n_q & (sel != sel_q);
endmodule

// File: rtl/bsl_store.sv
module bsl_store #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              commit,
  input  logic              din_q,
  input  logic [ADDR_W-1:0] sel_q,
  output logic [NBITS-1:0]  store_q
);
  logic [NBITS-1:0] store_nx;
  logic             store_en;

  assign store_en = ~clr_n | commit;

  always_comb begin
    store_nx = store_q;
    if (!clr_n)      store_nx = '0;
    else if (commit) store_nx[sel_q] = din_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        store_q <= '0;
    else if (store_en) store_q <= store_nx;
  end
endmodule

// File: rtl/bsl_outmux.sv
module bsl_outmux
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  bsl_mode_e         mode,
  input  logic              din,
  input  logic [ADDR_W-1:0] sel,
  input  logic              commit,
  input  logic              din_q,
  input  logic [ADDR_W-1:0] sel_q,
  input  logic [NBITS-1:0]  store_q,
  output logic [NBITS-1:0]  q
);
  for (genvar k = 0; k < NBITS; k++) begin : g_bit
    logic sel_hit;
    logic pend_hit;
    assign sel_hit  = (sel == ADDR_W'(k));
    assign pend_hit = commit & (sel_q == ADDR_W'(k));

    always_comb begin
      case (mode)
        MODE_WRITE: q[k] = sel_hit ? din : store_q[k];
        MODE_DEMUX: q[k] = sel_hit & din;
        MODE_HOLD:  q[k] = pend_hit ? din_q : store_q[k];
        default:    q[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bsl_addr_latch.sv
module bsl_addr_latch
  import bsl_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] sel,
  input  logic              wr_n,
  input  logic              clr_n,
  output logic [NBITS-1:0]  q,
  output logic              sel_chg_err
);
  logic              rst_sync_n;
  logic              din_q;
  logic [ADDR_W-1:0] sel_q;
  logic              wr_n_q;
  logic              commit;
  logic [NBITS-1:0]  store_q;
  bsl_mode_e         mode;

  assign mode = decode_mode(wr_n, clr_n);

  bsl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bsl_sampler #(.ADDR_W(ADDR_W)) u_smp (
    .clk(clk), .rst_n(rst_sync_n), .din(din), .sel(sel), .wr_n(wr_n),
    .din_q(din_q), .sel_q(sel_q), .wr_n_q(wr_n_q), .commit(commit),
    .sel_chg(sel_chg_err)
  );

  bsl_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .clr_n(clr_n), .commit(commit),
    .din_q(din_q), .sel_q(sel_q), .store_q(store_q)
  );

  bsl_outmux #(.ADDR_W(ADDR_W)) u_mux (
    .mode(mode), .din(din), .sel(sel), .commit(commit), .din_q(din_q),
    .sel_q(sel_q), .store_q(store_q), .q(q)
  );
endmodule

// File: rtl/bsl_addr_latch_chk.sv
module bsl_addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              din,
  input logic [ADDR_W-1:0] sel,
  input logic              wr_n,
  input logic              clr_n,
  input logic [NBITS-1:0]  q,
  input logic              sel_chg_err,
  input logic [NBITS-1:0]  store_q,
  input logic              din_q,
  input logic [ADDR_W-1:0] sel_q,
  input logic              wr_n_q
);
  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && clr_n) |-> (q[sel] == din));

  assert_commit_bit_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && !wr_n_q && clr_n) |=> (store_q[$past(sel_q)] == $past(din_q)));

  assert_commit_single_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && !wr_n_q && clr_n) |=> ($countones(store_q ^ $past(store_q)) <= 1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && wr_n_q && clr_n) |=> $stable(store_q));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_n && !clr_n) |=> (store_q == '0));

  assert_demux_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && !clr_n) |-> $onehot0(q));

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_chg_err |-> (!wr_n && !wr_n_q));
endmodule

bind bsl_addr_latch bsl_addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .din(din), .sel(sel), .wr_n(wr_n),
  .clr_n(clr_n), .q(q), .sel_chg_err(sel_chg_err), .store_q(store_q),
  .din_q(din_q), .sel_q(sel_q), .wr_n_q(wr_n_q)
);

// File: tb/bsl_addr_latch_tb.sv
`timescale 1ns/1ps
module bsl_addr_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       din;
  logic [2:0] sel;
  logic       wr_n;
  logic       clr_n;
  logic [7:0] q;
  logic       sel_chg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference state
  bit [7:0] m_word;
  bit       m_prev_en;
  bit       m_prev_d;
  bit [2:0] m_prev_a;
  logic [7:0] last_q;
  logic       last_err;

  always #2.5 clk = ~clk;

  bsl_addr_latch dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .wr_n(wr_n),
    .clr_n(clr_n), .q(q), .sel_chg_err(sel_chg_err)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] model_q(bit d, bit [2:0] a, bit en_n, bit cl_n);
    bit [7:0] e;
    if (!cl_n && !en_n)      begin e = '0; e[a] = d; end
    else if (!cl_n)          e = '0;
    else if (!en_n)          begin e = m_word; e[a] = d; end
    else if (!m_prev_en)     begin e = m_word; e[m_prev_a] = m_prev_d; end
    else                     e = m_word;
    return e;
  endfunction

  task automatic step(input bit d, input bit [2:0] a, input bit en_n, input bit cl_n,
                      input string tag);
    bit [7:0] eq;
    bit       ee;
    @(negedge clk);
    din = d; sel = a; wr_n = en_n; clr_n = cl_n;
    #1;
    eq = model_q(d, a, en_n, cl_n);
    ee = !en_n && !m_prev_en && (a != m_prev_a);
    last_q = q; last_err = sel_chg_err;
    chk(tag, {sel_chg_err, q}, {ee, eq});
    @(posedge clk);
    if (!cl_n)                 m_word = '0;
    else if (en_n && !m_prev_en) m_word[m_prev_a] = m_prev_d;
    m_prev_en = en_n; m_prev_d = d; m_prev_a = a;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    m_word = '0; m_prev_en = 1; m_prev_d = 0; m_prev_a = '0;
    rst_n = 0; din = 0; sel = 0; wr_n = 1; clr_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 reset word", {sel_chg_err, q}, 9'h000);
    rst_n = 1;
    repeat (3) step(1, 3'd5, 1, 1, "R8");
    chk("R8 no spurious commit", {last_err, last_q}, 9'h000);

    // walk every select, write ones
    for (int i = 0; i < 8; i++) begin
      step(1, 3'(i), 0, 1, "R1");
      step(1, 3'(i), 1, 1, "R2");
    end
    chk("R2 all ones", {1'b0, last_q}, 9'h0FF);
    // write zeros to 1,4,6
    step(0, 3'd1, 0, 1, "R1"); step(0, 3'd1, 1, 1, "R2");
    step(0, 3'd4, 0, 1, "R9"); step(0, 3'd4, 1, 1, "R9");
    step(0, 3'd6, 0, 1, "R9"); step(0, 3'd6, 1, 1, "R9");
    chk("R9 bit order", {1'b0, last_q}, 9'h0AD);

    // transparent follow
    for (int i = 0; i < 6; i++) step(i[0], 3'd2, 0, 1, "R1");
    step(1, 3'd2, 1, 1, "R2");

    // hold against changing inputs
    for (int i = 0; i < 12; i++) step(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 1, 1, "R3");
    chk("R3 hold", {1'b0, last_q}, 9'h0AD);

    // clear all
    step(1, 3'd0, 1, 0, "R4");
    chk("R4 immediate", {1'b0, last_q}, 9'h000);
    step(1, 3'd7, 1, 1, "R4");
    chk("R4 stored zero", {1'b0, last_q}, 9'h000);

    // fill some bits, then demultiplex over every select
    step(1, 3'd3, 0, 1, "R1"); step(1, 3'd3, 1, 1, "R2");
    for (int i = 0; i < 8; i++) begin
      step(1, 3'(i), 0, 0, "R5");
      chk("R5 one-hot", {1'b0, last_q}, {1'b0, 8'(1 << i)});
      step(0, 3'(i), 0, 0, "R5");
    end
    step(1, 3'd5, 0, 1, "R1");
    step(1, 3'd5, 1, 1, "R2");
    chk("R5 exit to single bit", {1'b0, last_q}, 9'h020);

    // commit colliding with clear
    step(1, 3'd0, 0, 1, "R6");
    step(1, 3'd0, 1, 0, "R6");
    step(0, 3'd2, 1, 1, "R6");
    chk("R6 clear wins", {1'b0, last_q}, 9'h000);

    // select change while strobe low
    step(0, 3'd3, 0, 1, "R7");
    step(0, 3'd6, 0, 1, "R7");
    chk("R7 flag", {last_err, 8'h00}, 9'h100);
    step(0, 3'd6, 0, 1, "R7");
    chk("R7 flag clears", {last_err, 8'h00}, 9'h000);
    step(0, 3'd6, 1, 1, "R2");

    done = 1;
    finish_run();
  end
endmodule